// File: doc/BRIEF.md
# Aspect-Ratio Selectable Single-Port RAM

This block is a 2048-bit single-port RAM whose word shape is picked by a static configuration input: 2048 words of 1 bit, 1024 words of 2 bits, or 512 words of 4 bits. The external pins do not change with the shape. There is always an 11-bit address, a 4-bit write data bus, a write enable and a 4-bit read data bus. Each shape uses only the low address bits and the low data bits it needs.

Two further static options set the latency. The first places a register stage in front of every input: address, write data and write enable are taken together as one 16-bit group. The second places a register stage on all four read-data bits. Each option either registers its whole group or bypasses it. Between the two stages the storage core reads combinationally and writes on the rising clock edge.

The core is built as four 512x1 lanes. Each shape maps its word onto one, two or four adjacent lanes at a shared row.

Top module: `shape_ram`

## Requirements
- R1: While rst_ni is low, rdata_o reads 0 when the output stage is enabled. The input stage holds write enable low, so a write strobe present during reset and removed before reset ends changes no word when the input stage is enabled.
- R2: shape_i = 0 selects 2048x1. The word address is addr_i[10:0], the write bit is wdata_i[0], the word appears on rdata_o[0], and rdata_o[3:1] read 0.
- R3: shape_i = 1 selects 1024x2. The word address is addr_i[9:0] and addr_i[10] is ignored. The write bits are wdata_i[1:0], the word appears on rdata_o[1:0], and rdata_o[3:2] read 0.
- R4: shape_i = 2 selects 512x4. The word address is addr_i[8:0], addr_i[10:9] are ignored, and all four data bits are used.
- R5: A word changes only on a rising clock edge at which the effective write enable is high. With the write enable low, data on wdata_i has no effect.
- R6: With both stages bypassed, rdata_o follows addr_i in the same cycle. Reading the address that is being written returns the old word until the edge.
- R7: With in_reg_i high, address, write data and write enable all act one clock later, as one group.
- R8: With out_reg_i high, all four bits of rdata_o show the core read value captured at the previous rising edge.
- R9: shape_i = 3 behaves exactly as 512x4.
- R10: Within one shape, distinct word addresses hold independent contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the storage and both register stages |
| rst_ni | input | 1 | Asynchronous active-low reset of the register stages |
| shape_i | input | 2 | Static word-shape select: 0 = 2048x1, 1 = 1024x2, 2 or 3 = 512x4 |
| in_reg_i | input | 1 | Static: 1 registers all inputs, 0 bypasses them |
| out_reg_i | input | 1 | Static: 1 registers read data, 0 bypasses it |
| addr_i | input | 11 | Word address |
| wdata_i | input | 4 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 4 | Read data, with unused upper bits held at 0 |

## Verification
In the fully bypassed path, read data is due in the same cycle as the address: the bench samples 1 ns after driving, before the next edge. That early sample is how it sees the old word during a write to the same address. Each enabled stage adds exactly one rising edge. A write becomes visible after the edge at which the effective write enable is high, which is one edge later when the input stage is on. The reference model steps on every rising edge: it captures the inputs, captures the combinational read and then applies the write. Its expected output is compared twice per cycle, once just after the inputs change and once at the falling edge. Words not yet written since the last shape change are tracked as unknown and skipped.

// File: rtl/shape_ram_pkg.sv
package shape_ram_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 4;

  typedef enum logic [1:0] {
    SHAPE_X1  = 2'd0,
    SHAPE_X2  = 2'd1,
    SHAPE_X4  = 2'd2,
    SHAPE_X4B = 2'd3
  } shape_e;
endpackage

// File: rtl/shape_ram_bank.sv
// Register stage with whole-group bypass.
module shape_ram_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q      <= '0;
      primed_q <= 1'b0;
    end else begin
      q_q      <= d_i;
      primed_q <= 1'b1;
    end
  end

  assign q_o = en_i ? q_q : d_i;

  // R7 and R8: an enabled stage presents the group sampled one edge earlier
  p_bank_delay_r7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && primed_q) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/shape_ram_lane.sv
// One bit-lane of storage: combinational read, edge write.
module shape_ram_lane #(
  parameter  int ROW_W = 9,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             d_i,
  output logic             rd_o
);
  logic cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[row_i] <= d_i;
  end

  assign rd_o = cells[row_i];
endmodule

// File: rtl/shape_ram_map.sv
// Maps a shaped word onto adjacent lanes at a shared row.
module shape_ram_map
  import shape_ram_pkg::*;
#(
  parameter  int ADDR_W = shape_ram_pkg::ADDR_W,
  parameter  int DATA_W = shape_ram_pkg::DATA_W,
  localparam int LANES  = DATA_W,
  localparam int SEL_W  = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - SEL_W
) (
  input  shape_e            shape_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  lane_rd_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic [LANES-1:0]  lane_wd_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    int lg;
    int wd;
    int bs;
    unique case (shape_i)
      SHAPE_X1: lg = 0;
      SHAPE_X2: lg = 1;
      default:  lg = SEL_W;
    endcase
    wd = 1 << lg;
    // lane base: low address bits left over once the row is taken
    bs = (int'(addr_i) & ((1 << (SEL_W - lg)) - 1)) << lg;
    row_o = ROW_W'(addr_i >> (SEL_W - lg));
    for (int l = 0; l < LANES; l++) begin
      if (l >= bs && l < bs + wd) begin
        lane_we_o[l] = we_i;
        lane_wd_o[l] = wdata_i[SEL_W'(l - bs)];
      end else begin
        lane_we_o[l] = 1'b0;
        lane_wd_o[l] = 1'b0;
      end
    end
    for (int k = 0; k < DATA_W; k++) begin
      rdata_o[k] = (k < wd) ? lane_rd_i[SEL_W'(bs + k)] : 1'b0;
    end
  end
endmodule

// File: rtl/shape_ram.sv
module shape_ram
  import shape_ram_pkg::*;
#(
  parameter  int ADDR_W = shape_ram_pkg::ADDR_W,
  parameter  int DATA_W = shape_ram_pkg::DATA_W,
  localparam int LANES  = DATA_W,
  localparam int SEL_W  = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - SEL_W,
  localparam int IN_W   = ADDR_W + DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        shape_i,
  input  logic              in_reg_i,
  input  logic              out_reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o
);
  shape_e            shape;
  logic [IN_W-1:0]   in_grp;
  logic [ADDR_W-1:0] core_addr;
  logic [DATA_W-1:0] core_wdata;
  logic              core_we;
  logic [DATA_W-1:0] core_rdata;
  logic [ROW_W-1:0]  row;
  logic [LANES-1:0]  lane_we;
  logic [LANES-1:0]  lane_wd;
  logic [LANES-1:0]  lane_rd;

  assign shape = shape_e'(shape_i);

  // reset value zero keeps write enable low
  shape_ram_bank #(.W(IN_W)) u_in_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_reg_i),
    .d_i    ({we_i, wdata_i, addr_i}),
    .q_o    (in_grp)
  );

  assign {core_we, core_wdata, core_addr} = in_grp;

  shape_ram_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .shape_i   (shape),
    .addr_i    (core_addr),
    .wdata_i   (core_wdata),
    .we_i      (core_we),
    .lane_rd_i (lane_rd),
    .row_o     (row),
    .lane_we_o (lane_we),
    .lane_wd_o (lane_wd),
    .rdata_o   (core_rdata)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    shape_ram_lane #(.ROW_W(ROW_W)) u_lane (
      .clk_i (clk_i),
      .we_i  (lane_we[g]),
      .row_i (row),
      .d_i   (lane_wd[g]),
      .rd_o  (lane_rd[g])
    );
  end

  shape_ram_bank #(.W(DATA_W)) u_out_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (out_reg_i),
    .d_i    (core_rdata),
    .q_o    (rdata_o)
  );

  p_x1_single_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape == SHAPE_X1) |-> $onehot0(lane_we));
  p_x1_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape == SHAPE_X1) |-> (core_rdata[DATA_W-1:1] == '0));
  p_x2_two_lanes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape == SHAPE_X2) |-> ($countones(lane_we) <= 2));
  p_x2_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape == SHAPE_X2) |-> (core_rdata[DATA_W-1:2] == '0));
  p_x4_all_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape == SHAPE_X4 || shape == SHAPE_X4B) |-> (lane_we == '0 || lane_we == '1));
  p_no_we_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_we |-> (lane_we == '0));
endmodule

// File: tb/shape_ram_test.sv
module shape_ram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  shape = 2'd2;
  logic        in_reg = 1'b1;
  logic        out_reg = 1'b1;
  logic [10:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        we = 1'b0;
  logic [3:0]  rdata;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int          ref_w [2048];
  bit          ref_k [2048];
  logic [10:0] cap_a;
  logic [3:0]  cap_d;
  logic        cap_we;
  int          oc_v;
  bit          oc_k;

  shape_ram uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .shape_i   (shape),
    .in_reg_i  (in_reg),
    .out_reg_i (out_reg),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .we_i      (we),
    .rdata_o   (rdata)
  );

  always #5 clk = ~clk;

  function automatic int width_of(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic int index_of(input logic [10:0] a);
    return int'(a) & (2048 / width_of(shape) - 1);
  endfunction

  function automatic void comb_read(output int v, output bit k);
    logic [10:0] a;
    a = in_reg ? cap_a : addr;
    k = ref_k[index_of(a)];
    v = ref_w[index_of(a)];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a = '0; cap_d = '0; cap_we = 1'b0;
      oc_v = 0; oc_k = 1'b1;
    end else begin
      int v; bit k;
      logic [10:0] ea; logic [3:0] ed; logic ew;
      comb_read(v, k);
      oc_v = v; oc_k = k;
      ea = in_reg ? cap_a : addr;
      ed = in_reg ? cap_d : wdata;
      ew = in_reg ? cap_we : we;
      if (ew) begin
        ref_w[index_of(ea)] = int'(ed) & ((1 << width_of(shape)) - 1);
        ref_k[index_of(ea)] = 1'b1;
      end
      cap_a = addr; cap_d = wdata; cap_we = we;
    end
  end

  task automatic check_now();
    int v; bit k;
    if (out_reg) begin v = oc_v; k = oc_k; end
    else comb_read(v, k);
    if (k) begin
      checks++;
      if (rdata !== 4'(v)) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h (shape %0d in %0b out %0b addr %h)",
                 cur_req, rdata, 4'(v), shape, in_reg, out_reg, addr);
      end
    end
  endtask

  task automatic cyc(input logic [10:0] a, input logic [3:0] d, input logic w);
    @(negedge clk);
    check_now();
    addr = a; wdata = d; we = w;
    #1;
    check_now();
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic ir, input logic orr);
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0;
    shape = m; in_reg = ir; out_reg = orr;
    for (int i = 0; i < 2048; i++) ref_k[i] = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog expired, actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin ref_k[i] = 1'b0; ref_w[i] = 0; end
    // R1: reset state with both stages on
    cur_req = "R1";
    repeat (3) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    cyc(11'h05a, 4'h9, 1'b1);
    cyc(11'h05a, 4'h0, 1'b0);
    cyc(11'h05a, 4'h0, 1'b0);
    cyc(11'h05a, 4'h0, 1'b0);
    // R1: write strobe during reset must not reach storage
    @(negedge clk);
    rst_n = 1'b0; addr = 11'h05a; wdata = 4'h6; we = 1'b1;
    @(negedge clk);
    check_now();
    @(negedge clk);
    we = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(11'h05a, 4'h0, 1'b0);

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        string mtag, ptag;
        int s, words;
        mtag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R9";
        ptag = (p == 0) ? "R6" : (p == 1) ? "R7" : (p == 2) ? "R8" : "R7+R8";
        set_cfg(2'(m), p[0], p[1]);
        s = (m == 0) ? 0 : (m == 1) ? 1 : 2;
        words = 2048 >> s;
        // R10 with ignored upper address bits varied between write and read
        cur_req = $sformatf("%s/%s/R10", mtag, ptag);
        for (int i = 0; i < 48; i++) begin
          int a;
          a = (i * 53 + 7) % words;
          cyc(11'(a | ((i * 7) << (11 - s))), 4'(i * 5 + 3), 1'b1);
        end
        for (int i = 0; i < 48; i++) begin
          int a;
          a = (i * 53 + 7) % words;
          cyc(11'(a | ((i * 3 + 1) << (11 - s))), 4'(i), 1'b0);
        end
        // R5: data with write enable low has no effect
        cur_req = $sformatf("%s/%s/R5", mtag, ptag);
        for (int i = 0; i < 16; i++) cyc(11'((i * 53 + 7) % words), 4'(~(i * 5 + 3)), 1'b0);
        for (int i = 0; i < 16; i++) cyc(11'((i * 53 + 7) % words), 4'h0, 1'b0);
        // R6: back-to-back writes to one address, old data before the edge
        cur_req = $sformatf("%s/%s/R6", mtag, ptag);
        cyc(11'(words - 1), 4'hf, 1'b1);
        cyc(11'(words - 1), 4'h5, 1'b1);
        cyc(11'(words - 1), 4'ha, 1'b1);
        cyc(11'(words - 1), 4'h0, 1'b0);
        cyc(11'h000, 4'h0, 1'b0);
        cyc(11'(words - 1), 4'h0, 1'b0);
        cyc(11'(words - 1), 4'h0, 1'b0);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule